// File: doc/BRIEF.md
# Reconfigurable Dual 8-bit Timer and PWM

This block pairs two 8-bit counter halves and lets a 2-bit mode field decide how they are used. In the split mode each half is its own interval timer. In the mixed mode the low half stays a timer and the high half becomes a free-running 8-bit PWM. In the cascaded mode both halves form one 16-bit interval timer. In the wide mode the pair becomes one PWM whose period is 2^N ticks, with N programmable from 9 to 16.

All counting advances only on cycles where the tick enable is high, so the prescaler can live elsewhere. Software programs the block through a simple write port. Address 0 holds the mode in bits [1:0]. Address 1 holds the low value. Address 2 holds the high value. Address 3 holds the width N in bits [4:0]. Address 4 clears flags: writing 1 to bit 0 clears the low flag, and writing 1 to bit 1 clears the high flag. Each half owns a sticky overflow flag, and the two flags are ORed onto one interrupt line.

Top module: `dual_timer_pwm`

## Requirements
- R1: After reset, the mode is split, both flags are clear, `irq` is low and `pwm_out` is low.
- R2: Counters and flags change only on a clock edge where `tick` is high. With `tick` low, no flag sets and `pwm_out` holds.
- R3: In mode 0 (split), each half counts up from zero once per tick. On a tick where its count equals or exceeds its match value, it reloads to zero and sets its own flag. The low half uses address 1 and the high half uses address 2. A match value M therefore sets the flag on the (M+1)th tick.
- R4: In mode 1 (mixed), the low half behaves as in R3. The high half counts 0 to 255 and wraps. `pwm_out` is high while its count is below the compare value from address 2. The high flag sets on the tick that wraps 255 to 0.
- R5: In mode 2 (cascaded), the 16-bit count reloads to zero and sets the high flag on a tick where it equals or exceeds {address 2, address 1}. The low flag never sets in this mode.
- R6: In mode 3 (wide), the period is 2^N ticks. N comes from address 3 and is clamped to the range 9 to 16. `pwm_out` is high while the count is below the low N bits of {address 2, address 1}. The high flag sets on the last tick of each period.
- R7: A new PWM compare value or width takes effect only at the next period boundary. The period in progress keeps the old duty.
- R8: Any write to the mode register restarts both counters at zero and loads the current compare value and width at once. No flag sets on that cycle.
- R9: Flags are sticky. Writing 1 to a flag's bit at address 4 clears it, and writing 0 leaves it unchanged. A set on the same edge wins over a clear.
- R10: `irq` is the OR of `irq_lo` and `irq_hi`. `pwm_out` is low in modes 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | PWM output |
| irq_lo | output | 1 | Low-half flag |
| irq_hi | output | 1 | High-half flag |
| irq | output | 1 | Shared interrupt, OR of both flags |

## Verification
The bench targets the following corner cases, and what a wrong design would show in each:
- **Off-by-one in timer reload.** Match values are chosen so that the flag must appear on exactly the (M+1)th tick. A design off by one would raise the flag one tick early or late.
- **Missing compare mask in wide mode.** A compare value with bits above the selected width must be masked. Without the mask the duty would be 512 instead of 356.
- **Missing width clamp.** Width codes below 9 and above 16 are programmed. Without the clamp the period would shrink to 32 ticks.
- **Immediate compare update.** The compare value is rewritten mid-period. A design that applies it at once would count 200 high ticks in that period instead of 64.
- **Flag handling.** Tests cover clearing with a 0 bit, clearing one flag only, and a mode rewrite that must restart the PWM phase. A design that ignores the restart would keep the output low.

// File: rtl/dtp_pkg.sv
// Shared types for the dual timer / PWM block.
// Assumes an 8-bit data path at the register port; addresses are fixed.
package dtp_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT   = 2'd0,
        MODE_MIXED   = 2'd1,
        MODE_CASCADE = 2'd2,
        MODE_WIDE    = 2'd3
    } dtp_mode_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LO    = 3'd1;
    localparam logic [ADDR_W-1:0] A_HI    = 3'd2;
    localparam logic [ADDR_W-1:0] A_WIDTH = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;
endpackage

// File: rtl/dtp_regfile.sv
// Register file: mode, low/high values, PWM width and flag-clear strobes.
// Assumes WIDTH_W <= HALF_W so the width field fits in one data write.
module dtp_regfile
    import dtp_pkg::*;
#(
    parameter int HALF_W  = 8,
    parameter int WIDTH_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [HALF_W-1:0]   wr_data,
    output dtp_mode_e           mode_q,
    output logic [HALF_W-1:0]   lo_q,
    output logic [HALF_W-1:0]   hi_q,
    output logic [WIDTH_W-1:0]  width_eff,
    output logic                mode_wr,
    output logic                clr_lo,
    output logic                clr_hi
);
    localparam int W_MIN = HALF_W + 1;
    localparam int W_MAX = 2 * HALF_W;

    logic [WIDTH_W-1:0] width_q;

    // Stores the programmable registers on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_SPLIT;
            lo_q    <= '1;
            hi_q    <= '1;
            width_q <= WIDTH_W'(W_MAX);
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE:  mode_q  <= dtp_mode_e'(wr_data[1:0]);
                A_LO:    lo_q    <= wr_data;
                A_HI:    hi_q    <= wr_data;
                A_WIDTH: width_q <= wr_data[WIDTH_W-1:0];
                default: ;
            endcase
        end
    end

    // Clamps the stored width into the legal range.
    always_comb begin
        if (width_q < WIDTH_W'(W_MIN))      width_eff = WIDTH_W'(W_MIN);
        else if (width_q > WIDTH_W'(W_MAX)) width_eff = WIDTH_W'(W_MAX);
        else                                width_eff = width_q;
    end

    // Decodes the one-cycle strobes for mode restart and flag clearing.
    always_comb begin
        mode_wr = wr_en && (wr_addr == A_MODE);
        clr_lo  = wr_en && (wr_addr == A_FLAGS) && wr_data[0];
        clr_hi  = wr_en && (wr_addr == A_FLAGS) && wr_data[1];
    end
endmodule

// File: rtl/dtp_core.sv
// Counter pair with mode-dependent reload and PWM compare.
// Assumes mode and values come from registers; the compare value and width
// are latched at period boundaries or on a mode write.
module dtp_core
    import dtp_pkg::*;
#(
    parameter int HALF_W  = 8,
    parameter int WIDTH_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  dtp_mode_e           mode,
    input  logic [HALF_W-1:0]   lo_val,
    input  logic [HALF_W-1:0]   hi_val,
    input  logic [WIDTH_W-1:0]  width_eff,
    input  logic                mode_wr,
    output logic                pwm_out,
    output logic                set_lo,
    output logic                set_hi
);
    localparam int FULL_W = 2 * HALF_W;

    logic [HALF_W-1:0]  cnt_lo, cnt_hi, lo_nxt, hi_nxt;
    logic [FULL_W-1:0]  cnt_full, cmp_act, mask_act;
    logic [WIDTH_W-1:0] width_act;
    logic               hit_lo, hit_hi, load_cmp;
    logic               lo_hit, hi_hit, full_hit, hi_top, wide_end;

    // Builds a mask of the low n bits.
    function automatic logic [FULL_W-1:0] low_mask(input logic [WIDTH_W-1:0] n);
        logic [FULL_W-1:0] m;
        for (int i = 0; i < FULL_W; i++) m[i] = (i < int'(n));
        return m;
    endfunction

    assign cnt_full = {cnt_hi, cnt_lo};
    assign mask_act = low_mask(width_act);

    // Evaluates the terminal conditions of every counting arrangement.
    always_comb begin
        lo_hit   = cnt_lo >= lo_val;
        hi_hit   = cnt_hi >= hi_val;
        full_hit = cnt_full >= {hi_val, lo_val};
        hi_top   = &cnt_hi;
        wide_end = cnt_full == mask_act;
    end

    // Selects next counts, flag hits and compare loads per mode.
    always_comb begin
        lo_nxt   = cnt_lo;
        hi_nxt   = cnt_hi;
        hit_lo   = 1'b0;
        hit_hi   = 1'b0;
        load_cmp = 1'b0;
        case (mode)
            MODE_SPLIT: begin
                lo_nxt = lo_hit ? '0 : cnt_lo + HALF_W'(1);
                hi_nxt = hi_hit ? '0 : cnt_hi + HALF_W'(1);
                hit_lo = lo_hit;
                hit_hi = hi_hit;
            end
            MODE_MIXED: begin
                lo_nxt   = lo_hit ? '0 : cnt_lo + HALF_W'(1);
                hi_nxt   = cnt_hi + HALF_W'(1);
                hit_lo   = lo_hit;
                hit_hi   = hi_top;
                load_cmp = hi_top;
            end
            MODE_CASCADE: begin
                {hi_nxt, lo_nxt} = full_hit ? '0 : cnt_full + FULL_W'(1);
                hit_hi = full_hit;
            end
            default: begin
                {hi_nxt, lo_nxt} = wide_end ? '0 : cnt_full + FULL_W'(1);
                hit_hi   = wide_end;
                load_cmp = wide_end;
            end
        endcase
    end

    // Advances counters on tick and restarts them on a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo    <= '0;
            cnt_hi    <= '0;
            cmp_act   <= '0;
            width_act <= WIDTH_W'(FULL_W);
        end else if (mode_wr) begin
            cnt_lo    <= '0;
            cnt_hi    <= '0;
            cmp_act   <= {hi_val, lo_val};
            width_act <= width_eff;
        end else if (tick) begin
            cnt_lo <= lo_nxt;
            cnt_hi <= hi_nxt;
            if (load_cmp) begin
                cmp_act   <= {hi_val, lo_val};
                width_act <= width_eff;
            end
        end
    end

    // Produces flag set pulses, suppressed on the restart cycle.
    always_comb begin
        set_lo = tick && !mode_wr && hit_lo;
        set_hi = tick && !mode_wr && hit_hi;
    end

    // Compares the running count with the latched compare value.
    always_comb begin
        case (mode)
            MODE_MIXED: pwm_out = cnt_hi < cmp_act[FULL_W-1:HALF_W];
            MODE_WIDE:  pwm_out = cnt_full < (cmp_act & mask_act);
            default:    pwm_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/dtp_flags.sv
// Sticky interrupt flags, one per half; set has priority over clear.
// Assumes set and clear are single-cycle pulses.
module dtp_flags #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set,
    input  logic [N_FLAGS-1:0] clr,
    output logic [N_FLAGS-1:0] flag_q
);
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        // Holds one flag until it is cleared by a write of 1.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q[g] <= 1'b0;
            else if (set[g]) flag_q[g] <= 1'b1;
            else if (clr[g]) flag_q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_timer_pwm.sv
// Top: dual 8-bit timer / PWM with four counting arrangements.
// Assumes tick is a synchronous enable from an external prescaler.
module dual_timer_pwm
    import dtp_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq
);
    localparam int WIDTH_W = $clog2(2 * HALF_W + 1);

    dtp_mode_e          mode_q;
    logic [HALF_W-1:0]  lo_q, hi_q;
    logic [WIDTH_W-1:0] width_eff;
    logic               mode_wr, clr_lo, clr_hi, set_lo, set_hi;
    logic [1:0]         flags;

    dtp_regfile #(.HALF_W(HALF_W), .WIDTH_W(WIDTH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_q(mode_q), .lo_q(lo_q), .hi_q(hi_q),
        .width_eff(width_eff), .mode_wr(mode_wr), .clr_lo(clr_lo),
        .clr_hi(clr_hi)
    );

    dtp_core #(.HALF_W(HALF_W), .WIDTH_W(WIDTH_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q),
        .lo_val(lo_q), .hi_val(hi_q), .width_eff(width_eff),
        .mode_wr(mode_wr), .pwm_out(pwm_out), .set_lo(set_lo),
        .set_hi(set_hi)
    );

    dtp_flags #(.N_FLAGS(2)) u_flags (
        .clk(clk), .rst_n(rst_n), .set({set_hi, set_lo}),
        .clr({clr_hi, clr_lo}), .flag_q(flags)
    );

    // Exposes each flag and the shared interrupt line.
    always_comb begin
        irq_lo = flags[0];
        irq_hi = flags[1];
        irq    = |flags;
    end
endmodule

// File: rtl/dtp_checker.sv
// Assertion checker bound to the top; observes ports and the mode register.
module dtp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [1:0] wr_bits,
    input logic [1:0] mode,
    input logic       pwm_out,
    input logic       irq_lo,
    input logic       irq_hi
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(pwm_out) && $stable(irq_lo) && $stable(irq_hi)));

    // R9
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && !(wr_en && wr_addr == 3'd4 && wr_bits[0])) |=> irq_lo);

    // R9
    hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && !(wr_en && wr_addr == 3'd4 && wr_bits[1])) |=> irq_hi);

    // R5
    cascade_lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !irq_lo) |=> !irq_lo);

    // R10
    pwm_idle_modes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 || mode == 2'd2) |-> !pwm_out);
endmodule

bind dual_timer_pwm dtp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_bits(wr_data[1:0]), .mode(mode_q),
    .pwm_out(pwm_out), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tb_dual_timer_pwm.sv
`timescale 1ns/1ps
module tb_dual_timer_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out, irq_lo, irq_hi, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_timer_pwm dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [4:0]  width;
        logic [31:0] ticks;
        logic [31:0] high;
        logic        lo_f;
        logic        hi_f;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd3,   8'd10,  5'd16, 32'd4,    32'd0,    1'b1, 1'b0},
        '{2'd0, 8'd10,  8'd3,   5'd16, 32'd4,    32'd0,    1'b0, 1'b1},
        '{2'd1, 8'd200, 8'd64,  5'd16, 32'd256,  32'd64,   1'b1, 1'b1},
        '{2'd1, 8'd0,   8'd0,   5'd16, 32'd256,  32'd0,    1'b1, 1'b1},
        '{2'd2, 8'h2C,  8'h01,  5'd16, 32'd300,  32'd0,    1'b0, 1'b0},
        '{2'd2, 8'h2C,  8'h01,  5'd16, 32'd301,  32'd0,    1'b0, 1'b1},
        '{2'd3, 8'h64,  8'h00,  5'd9,  32'd512,  32'd100,  1'b0, 1'b1},
        '{2'd3, 8'h64,  8'h03,  5'd9,  32'd512,  32'd356,  1'b0, 1'b1},
        '{2'd3, 8'h00,  8'h02,  5'd10, 32'd1023, 32'd512,  1'b0, 1'b0},
        '{2'd3, 8'hFF,  8'h01,  5'd5,  32'd512,  32'd511,  1'b0, 1'b1},
        '{2'd3, 8'h00,  8'h80,  5'd20, 32'd1000, 32'd1000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, output int high);
        high = 0;
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) high++;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        int h1, h2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "pwm_out after reset", pwm_out, 0);
        chk("R1", "irq_lo after reset", irq_lo, 0);
        chk("R1", "irq_hi after reset", irq_hi, 0);
        chk("R1", "irq after reset", irq, 0);

        // Table of vectors
        for (int v = 0; v < NV; v++) begin
            wr(3'd1, VECS[v].lo);
            wr(3'd2, VECS[v].hi);
            wr(3'd3, {3'b000, VECS[v].width});
            wr(3'd0, {6'b0, VECS[v].mode});
            wr(3'd4, 8'h03);
            run(int'(VECS[v].ticks), h1);
            chk((VECS[v].mode == 2'd0 || VECS[v].mode == 2'd2) ? "R10" : mode_tag(VECS[v].mode),
                $sformatf("vec%0d pwm high ticks", v), h1, int'(VECS[v].high));
            chk(mode_tag(VECS[v].mode), $sformatf("vec%0d irq_lo", v), irq_lo, int'(VECS[v].lo_f));
            chk(mode_tag(VECS[v].mode), $sformatf("vec%0d irq_hi", v), irq_hi, int'(VECS[v].hi_f));
        end

        // R2 tick gating: match 0 would fire on any tick
        wr(3'd1, 8'd0);
        wr(3'd2, 8'd0);
        wr(3'd0, 8'd0);
        wr(3'd4, 8'h03);
        repeat (20) @(negedge clk);
        chk("R2", "irq_lo with tick low", irq_lo, 0);
        chk("R2", "irq_hi with tick low", irq_hi, 0);
        run(1, h1);
        chk("R3", "irq_lo after one tick, match 0", irq_lo, 1);
        chk("R3", "irq_hi after one tick, match 0", irq_hi, 1);

        // R9 clear semantics, R10 shared line
        wr(3'd4, 8'h00);
        chk("R9", "irq_lo after write of 0", irq_lo, 1);
        chk("R9", "irq_hi after write of 0", irq_hi, 1);
        wr(3'd4, 8'h01);
        chk("R9", "irq_lo after clear bit0", irq_lo, 0);
        chk("R9", "irq_hi after clear bit0", irq_hi, 1);
        chk("R10", "irq with only hi flag", irq, 1);
        wr(3'd4, 8'h02);
        chk("R10", "irq with no flag", irq, 0);

        // R7 compare update deferred to period boundary
        wr(3'd1, 8'd255);
        wr(3'd2, 8'd64);
        wr(3'd0, 8'd1);
        run(10, h1);
        wr(3'd2, 8'd200);
        run(246, h2);
        chk("R7", "high ticks in period with mid-period rewrite", h1 + h2, 64);
        run(256, h1);
        chk("R7", "high ticks in following period", h1, 200);

        // R8 mode rewrite restarts phase
        wr(3'd1, 8'd100);
        wr(3'd2, 8'd0);
        wr(3'd3, 8'd9);
        wr(3'd0, 8'd3);
        run(300, h1);
        chk("R6", "pwm_out at count 300, compare 100", pwm_out, 0);
        wr(3'd0, 8'd3);
        chk("R8", "pwm_out right after mode rewrite", pwm_out, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule